// File: doc/BRIEF.md
# Carry Select Adder with Increment Converter

This block is a purely combinational binary adder that takes two operands and a carry-in and returns their sum and a carry-out. The operand width is a parameter and must be a whole number of 4-bit groups. Inside each group a ripple chain adds the operand slices as if no carry were coming in. A small increment converter then derives, from that carry-zero result, the value the group would produce if a carry of one arrived. No second ripple chain is needed for this.

The carry that really arrives at a group does not ripple through it. It only drives a row of 2:1 selectors that choose between the two candidate sums and carry-outs, which were prepared beforehand. Groups are chained: the chosen carry-out of one group becomes the select of the next. A parameter decides how the lowest group is built. It can feed the block's carry-in straight into its ripple chain, or treat it like every other group, with a converter and selectors.

There is no clock and no reset. The outputs settle from the inputs alone.

Top module: `csa_bec_adder`

## Requirements
- R1: For every input combination, the concatenation {co, sum} equals a + b + cin, computed as an unsigned value one bit wider than the operands.
- R2: sum[3:0] equals the low four bits of a[3:0] + b[3:0] + cin, regardless of the upper operand bits.
- R3: For any a and b, the result {co, sum} with cin = 1 is exactly one more than the result with cin = 0, taken modulo 2^(WIDTH+1).
- R4: When b is the bitwise complement of a, cin = 0 gives sum all ones with co = 0, and cin = 1 gives sum all zeros with co = 1.
- R5: When b is zero, {co, sum} equals a + cin.
- R6: At a width of 4 the adder gives: 5+10+0 = sum 15, co 0; 5+10+1 = sum 0, co 1; 15+10+0 = sum 9, co 1; 15+11+1 = sum 11, co 1.
- R7: A carry made in one group reaches the groups above it through their selectors. For example, 0x0FFF+0x0001 gives 0x1000, and 0xFFFF+0x0000+1 gives sum 0 with co 1.
- R8: Both ways of building the lowest group (carry-in fed into the ripple chain, or carry-in used as a selector) give identical results for all 512 input combinations at a width of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the lowest bit |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| co | output | 1 | Carry out of the top bit |

## Verification
The checker assumes only that every input holds a defined 0 or 1 once it has been applied. It samples the outputs after the combinational paths have settled, so it never looks at a value while the inputs are still changing. The bench changes the inputs on the rising clock edge and reads the outputs on the falling edge, which leaves half a period for the carry to pass through the selectors. At a width of 4 it drives every operand pair and carry. At a width of 16 it uses a table of boundary values followed by random pairs drawn from the full range, so no input ever goes outside the legal two-valued domain.

// File: rtl/csa_pkg.sv
package csa_pkg;
   // Width of one carry-select group; the converter and selectors are sized from it.
   localparam int unsigned GRP_W = 4;

   function automatic int unsigned grp_count(input int unsigned width);
      return width / GRP_W;
   endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
   parameter int unsigned W = csa_pkg::GRP_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   logic [W:0] chain;
   assign chain[0] = ci;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign s[i]       = a[i] ^ b[i] ^ chain[i];
      assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
   end

   assign co = chain[W];
endmodule

// File: rtl/csa_excess1.sv
module csa_excess1 #(
   parameter int unsigned W = csa_pkg::GRP_W
) (
   input  logic [W-1:0] s0,
   input  logic         c0,
   output logic [W-1:0] s1,
   output logic         c1
);
   // run[i] is high when every bit below i is one, so bit i toggles.
   logic [W:0] run;
   assign run[0] = 1'b1;

   for (genvar i = 0; i < W; i++) begin : g_inc
      assign s1[i]    = s0[i] ^ run[i];
      assign run[i+1] = run[i] & s0[i];
   end

   // Carry-one case overflows if carry-zero did, or if the slice was all ones.
   assign c1 = c0 | run[W];
endmodule

// File: rtl/csa_group.sv
module csa_group #(
   parameter int unsigned W          = csa_pkg::GRP_W,
   parameter bit          DIRECT_CIN = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   if (DIRECT_CIN) begin : g_direct
      csa_ripple #(.W(W)) u_rca (.a(a), .b(b), .ci(ci), .s(s), .co(co));
   end else begin : g_select
      logic [W-1:0] sum_z, sum_o;
      logic         cry_z, cry_o;

      csa_ripple #(.W(W)) u_rca (
         .a(a), .b(b), .ci(1'b0), .s(sum_z), .co(cry_z)
      );
      csa_excess1 #(.W(W)) u_inc (
         .s0(sum_z), .c0(cry_z), .s1(sum_o), .c1(cry_o)
      );

      assign s  = ci ? sum_o : sum_z;
      assign co = ci ? cry_o : cry_z;
   end
endmodule

// File: rtl/csa_bec_adder.sv
module csa_bec_adder #(
   parameter int unsigned WIDTH        = 16,
   parameter bit          FIRST_DIRECT = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             co
);
   import csa_pkg::*;

   localparam int unsigned NGRP = grp_count(WIDTH);

   if (WIDTH == 0 || (WIDTH % GRP_W) != 0) begin : g_bad_width
      $error("csa_bec_adder: WIDTH must be a nonzero multiple of the group width");
   end

   logic [NGRP:0] gcarry;
   assign gcarry[0] = cin;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      csa_group #(
         .W         (GRP_W),
         .DIRECT_CIN((g == 0) && FIRST_DIRECT)
      ) u_grp (
         .a (a[g*GRP_W +: GRP_W]),
         .b (b[g*GRP_W +: GRP_W]),
         .ci(gcarry[g]),
         .s (sum[g*GRP_W +: GRP_W]),
         .co(gcarry[g+1])
      );
   end

   assign co = gcarry[NGRP];
endmodule

// File: rtl/csa_bec_adder_chk.sv
module csa_bec_adder_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             cin,
   input logic [WIDTH-1:0] sum,
   input logic             co
);
   logic [WIDTH:0] total;
   logic [4:0]     low_total;
   assign total     = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
   assign low_total = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};

   always_comb begin
      a_r1_total : assert ({co, sum} == total)
         else $error("R1 total mismatch");
      a_r2_low_group : assert (sum[3:0] == low_total[3:0])
         else $error("R2 low group mismatch");
      if (b == ~a) begin
         a_r4_complement : assert ({co, sum} == (cin ? {1'b1, {WIDTH{1'b0}}} : {1'b0, {WIDTH{1'b1}}}))
            else $error("R4 complement mismatch");
      end
      if (b == '0) begin
         a_r5_zero_addend : assert ({co, sum} == ({1'b0, a} + {{WIDTH{1'b0}}, cin}))
            else $error("R5 zero addend mismatch");
      end
   end
endmodule

bind csa_bec_adder csa_bec_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .a(a), .b(b), .cin(cin), .sum(sum), .co(co)
);

// File: tb/sim_csa_bec_adder.sv
`timescale 1ns/1ps
module sim_csa_bec_adder;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int errors = 0;
   int checks = 0;

   logic [15:0] a16 = '0, b16 = '0;
   logic        c16 = 1'b0;
   logic [15:0] s16;
   logic        o16;

   logic [3:0]  a4 = '0, b4 = '0;
   logic        c4 = 1'b0;
   logic [3:0]  s4_sel, s4_dir;
   logic        o4_sel, o4_dir;

   csa_bec_adder #(.WIDTH(16), .FIRST_DIRECT(1'b1)) u0 (
      .a(a16), .b(b16), .cin(c16), .sum(s16), .co(o16));
   csa_bec_adder #(.WIDTH(4), .FIRST_DIRECT(1'b0)) u1 (
      .a(a4), .b(b4), .cin(c4), .sum(s4_sel), .co(o4_sel));
   csa_bec_adder #(.WIDTH(4), .FIRST_DIRECT(1'b1)) u2 (
      .a(a4), .b(b4), .cin(c4), .sum(s4_dir), .co(o4_dir));

   // Row: a, b, cin, expected {co,sum}
   localparam int NV = 12;
   localparam logic [16+16+1+17-1:0] VEC [NV] = '{
      {16'h0000, 16'h0000, 1'b0, 17'h00000},
      {16'h0005, 16'h000A, 1'b0, 17'h0000F},
      {16'h0FFF, 16'h0001, 1'b0, 17'h01000},
      {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
      {16'h1234, 16'hEDCB, 1'b0, 17'h0FFFF},
      {16'h1234, 16'hEDCB, 1'b1, 17'h10000},
      {16'h8000, 16'h8000, 1'b0, 17'h10000},
      {16'h00F0, 16'h0010, 1'b1, 17'h00101},
      {16'hABCD, 16'h0000, 1'b1, 17'h0ABCE},
      {16'h7FFF, 16'h0001, 1'b0, 17'h08000},
      {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
      {16'h0F0F, 16'h00F1, 1'b0, 17'h01000}
   };

   task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic ci);
      @(posedge clk);
      a16 = a; b16 = b; c16 = ci;
      @(negedge clk);
   endtask

   task automatic cmp(input string tag, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [16:0] r0, r1;
      // Idle state with all inputs at zero
      @(negedge clk);
      cmp("R1 idle 16b", {o16, s16}, 17'h0);
      cmp("R1 idle 4b", {12'h0, o4_sel, s4_sel}, 17'h0);

      // Table walk (R1, R4, R5, R7 boundary rows)
      for (int i = 0; i < NV; i++) begin
         apply16(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
         cmp("R1/R7 table", {o16, s16}, VEC[i][16:0]);
      end

      // R6 directed 4-bit vectors
      @(posedge clk); a4 = 4'd5;  b4 = 4'd10; c4 = 1'b0; @(negedge clk);
      cmp("R6 5+10+0", {12'h0, o4_sel, s4_sel}, {12'h0, 1'b0, 4'd15});
      @(posedge clk); a4 = 4'd5;  b4 = 4'd10; c4 = 1'b1; @(negedge clk);
      cmp("R6 5+10+1", {12'h0, o4_sel, s4_sel}, {12'h0, 1'b1, 4'd0});
      @(posedge clk); a4 = 4'd15; b4 = 4'd10; c4 = 1'b0; @(negedge clk);
      cmp("R6 15+10+0", {12'h0, o4_sel, s4_sel}, {12'h0, 1'b1, 4'd9});
      @(posedge clk); a4 = 4'd15; b4 = 4'd11; c4 = 1'b1; @(negedge clk);
      cmp("R6 15+11+1", {12'h0, o4_sel, s4_sel}, {12'h0, 1'b1, 4'd11});

      // Exhaustive 4-bit: R1 on both variants, R8 equality between them
      for (int x = 0; x < 512; x++) begin
         logic [4:0] e;
         @(posedge clk);
         a4 = x[3:0]; b4 = x[7:4]; c4 = x[8];
         e = {1'b0, a4} + {1'b0, b4} + {4'b0, c4};
         @(negedge clk);
         cmp("R1 exhaustive select-first", {12'h0, o4_sel, s4_sel}, {12'h0, e});
         cmp("R8 variants agree", {12'h0, o4_dir, s4_dir}, {12'h0, o4_sel, s4_sel});
      end

      // R4 complement and R5 zero addend at 16 bits
      for (int k = 0; k < 40; k++) begin
         logic [15:0] ra;
         ra = 16'($urandom);
         apply16(ra, ~ra, 1'b0);
         cmp("R4 complement cin0", {o16, s16}, {1'b0, 16'hFFFF});
         apply16(ra, ~ra, 1'b1);
         cmp("R4 complement cin1", {o16, s16}, 17'h10000);
         apply16(ra, 16'h0, 1'b1);
         cmp("R5 zero addend", {o16, s16}, {1'b0, ra} + 17'd1);
      end

      // R7 carry run across group boundaries
      for (int g = 1; g <= 4; g++) begin
         logic [15:0] ones;
         ones = 16'((32'd1 << (4 * g)) - 1);
         apply16(ones, 16'h0001, 1'b0);
         cmp("R7 boundary carry", {o16, s16}, {1'b0, ones} + 17'd1);
      end

      // Random pairs: R1 total, R2 low group, R3 carry-in increments by one
      for (int k = 0; k < 800; k++) begin
         logic [15:0] ra, rb;
         logic [4:0]  lo;
         ra = 16'($urandom);
         rb = 16'($urandom);
         apply16(ra, rb, 1'b0);
         r0 = {o16, s16};
         cmp("R1 random cin0", r0, {1'b0, ra} + {1'b0, rb});
         apply16(ra, rb, 1'b1);
         r1 = {o16, s16};
         cmp("R3 cin increments", r1, r0 + 17'd1);
         lo = {1'b0, ra[3:0]} + {1'b0, rb[3:0]} + 5'd1;
         cmp("R2 low group", {13'h0, s16[3:0]}, {13'h0, lo[3:0]});
      end

      finish_run();
   end
endmodule